// File: doc/BRIEF.md
# Segmented memory region decoder

This block sorts every access on a 24-bit microcontroller bus into one of three destinations: a small on-chip RAM fixed at a 2 KB page near the top of the first 64 KB, a second on-chip RAM reached through a window whose base and size software can reprogram, or the external memory bus. The decision is combinational, so an on-chip hit is acknowledged in the same cycle it is presented. For external accesses the block also drives the high-order segment lines. Depending on the configured segmentation mode it drives none, two, four or all eight of them.

A system configuration register holds the segmentation mode and a sharing bit. The sharing bit allows a second bus master to reach the fixed on-chip RAM while the core sits in hold. Once boot code pulses the end-of-initialisation strobe, that register is frozen until the next reset. The window register stays writable at all times.

Top module: `seg_region_decoder`

## Requirements
- R1: Byte accesses and even word accesses to 0x00E000 through 0x00E7FF assert `sel_ram1`, and the addresses just outside that range do not.
- R2: After reset the window covers 0x0F0000 through 0x0FFFFF. Accesses there that miss the fixed page assert `sel_ram2`.
- R3: A window write (`cfg_sel`=1) loads the base page from `cfg_wdata[7:0]` and a compare mask from `cfg_wdata[15:8]`. An address hits when `(addr[23:16] ^ base) & mask` is zero. Window writes take effect in the cycle after the write edge, even after the lock has engaged.
- R4: When the window overlaps the fixed page, the fixed page wins.
- R5: A valid, aligned access that hits neither on-chip region asserts `sel_ext`. A valid, aligned access asserts exactly one select.
- R6: A word access (`req_word`=1) to an odd address raises `align_err` in that cycle. It asserts no select and no ready.
- R7: `req_ready` is high in the same cycle for every on-chip hit and low for every external access.
- R8: `seg_addr` carries `addr[17:16]`, `addr[19:16]` or `addr[23:16]` for segmentation mode 1, 2 or 3. The other bits are zero, all bits are zero in mode 0, and the whole port is zero unless `sel_ext` is high.
- R9: `xm_sel_ram1` is high only when `xm_valid`, `core_hold` and the sharing bit are all set and `xm_addr` falls in the fixed page.
- R10: A system register write (`cfg_sel`=0) stores the sharing bit from `cfg_wdata[0]` and the mode from `cfg_wdata[2:1]`. Such a write is ignored in the cycle of the `init_done` strobe and in every later cycle until reset.
- R11: Reset clears the sharing bit, the mode (to 0) and the lock, and restores the default window. With no request, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Core access present |
| req_addr | input | 24 | Core byte address |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = system register, 1 = window register |
| cfg_wdata | input | 16 | Configuration write data |
| init_done | input | 1 | End-of-initialisation strobe |
| core_hold | input | 1 | Core is in hold, bus granted away |
| xm_valid | input | 1 | External master access present |
| xm_addr | input | 24 | External master byte address |
| sel_ram1 | output | 1 | Fixed on-chip RAM selected |
| sel_ram2 | output | 1 | Windowed on-chip RAM selected |
| sel_ext | output | 1 | External bus selected |
| req_ready | output | 1 | Zero-wait completion for on-chip hits |
| align_err | output | 1 | Odd word access flagged |
| seg_addr | output | 8 | Segment address lines |
| xm_sel_ram1 | output | 1 | External master granted fixed RAM |

## Verification
The only state in this block is its configuration, so a wrong internal value shows up in the first access decoded after it. A stale or corrupted mode changes the masking of `seg_addr` on the next external access. A bad window base or mask moves pages between `sel_ram2` and `sel_ext`. A lock that fails to engage, or that clears, lets a later system write change the segment width or sharing, and the next access reveals it. Sweeping all 256 upper pages under each mode and window setting therefore exposes any such fault within one cycle of the access that depends on it.

// File: rtl/seg_dec_pkg.sv
package seg_dec_pkg;

    typedef enum logic [1:0] {
        SEG_NONE = 2'b00,
        SEG_2BIT = 2'b01,
        SEG_4BIT = 2'b10,
        SEG_8BIT = 2'b11
    } seg_mode_e;

    typedef enum logic {
        CFG_SYS = 1'b0,
        CFG_WIN = 1'b1
    } cfg_target_e;

    localparam int SYS_SHARE_BIT = 0;
    localparam int SYS_MODE_LSB  = 1;

    typedef struct packed {
        logic ram1;
        logic ram2;
        logic ext;
        logic ready;
        logic err;
    } req_dec_t;

endpackage

// File: rtl/seg_cfg_regs.sv
module seg_cfg_regs
    import seg_dec_pkg::*;
#(
    parameter int                PAGE_W       = 8,
    parameter int                DATA_W       = 16,
    parameter logic [PAGE_W-1:0] WIN_BASE_RST = 8'h0F,
    parameter logic [PAGE_W-1:0] WIN_MASK_RST = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              init_strobe,
    output logic              share,
    output seg_mode_e         mode,
    output logic              locked,
    output logic [PAGE_W-1:0] win_base,
    output logic [PAGE_W-1:0] win_mask
);

    typedef struct packed {
        logic              share;
        seg_mode_e         mode;
        logic              locked;
        logic [PAGE_W-1:0] base;
        logic [PAGE_W-1:0] mask;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    logic sys_wr_ok;
    logic win_wr_ok;

    always_comb begin
        st_d      = st_q;
        sys_wr_ok = wr_en && (wr_sel == CFG_SYS) && !st_q.locked && !init_strobe;
        win_wr_ok = wr_en && (wr_sel == CFG_WIN);
        if (init_strobe) begin
            st_d.locked = 1'b1;
        end
        if (sys_wr_ok) begin
            st_d.share = wr_data[SYS_SHARE_BIT];
            st_d.mode  = seg_mode_e'(wr_data[SYS_MODE_LSB +: 2]);
        end
        if (win_wr_ok) begin
            st_d.base = wr_data[PAGE_W-1:0];
            st_d.mask = wr_data[2*PAGE_W-1:PAGE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.share  <= 1'b0;
            st_q.mode   <= SEG_NONE;
            st_q.locked <= 1'b0;
            st_q.base   <= WIN_BASE_RST;
            st_q.mask   <= WIN_MASK_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign share    = st_q.share;
    assign mode     = st_q.mode;
    assign locked   = st_q.locked;
    assign win_base = st_q.base;
    assign win_mask = st_q.mask;

endmodule

// File: rtl/seg_fixed_match.sv
module seg_fixed_match #(
    parameter int                ADDR_W    = 24,
    parameter int                PAGE_LOG2 = 11,
    parameter logic [ADDR_W-1:0] PAGE_BASE = 24'h00E000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    localparam int TAG_W = ADDR_W - PAGE_LOG2;
    localparam logic [TAG_W-1:0] PAGE_TAG = PAGE_BASE[ADDR_W-1:PAGE_LOG2];

    logic unused_offset;
    assign unused_offset = ^addr[PAGE_LOG2-1:0];

    assign hit = (addr[ADDR_W-1:PAGE_LOG2] == PAGE_TAG);

endmodule

// File: rtl/seg_window_match.sv
module seg_window_match #(
    parameter int PAGE_W = 8
) (
    input  logic [PAGE_W-1:0] page,
    input  logic [PAGE_W-1:0] base,
    input  logic [PAGE_W-1:0] mask,
    output logic              hit
);

    logic [PAGE_W-1:0] diff;

    always_comb begin
        diff = (page ^ base) & mask;
        hit  = (diff == '0);
    end

endmodule

// File: rtl/seg_addr_out.sv
module seg_addr_out
    import seg_dec_pkg::*;
#(
    parameter int PAGE_W = 8
) (
    input  logic [PAGE_W-1:0] page,
    input  seg_mode_e         mode,
    input  logic              en,
    output logic [PAGE_W-1:0] seg
);

    localparam int NARROW_W = 2;
    localparam int MID_W    = 4;

    for (genvar i = 0; i < PAGE_W; i++) begin : g_bit
        if (i < NARROW_W) begin : g_narrow
            assign seg[i] = en & page[i] & (mode != SEG_NONE);
        end else if (i < MID_W) begin : g_mid
            assign seg[i] = en & page[i] & ((mode == SEG_4BIT) | (mode == SEG_8BIT));
        end else begin : g_wide
            assign seg[i] = en & page[i] & (mode == SEG_8BIT);
        end
    end

endmodule

// File: rtl/seg_region_decoder.sv
module seg_region_decoder
    import seg_dec_pkg::*;
#(
    parameter int                            ADDR_W       = 24,
    parameter int                            OFS_W        = 16,
    parameter int                            DATA_W       = 16,
    parameter int                            RAM1_LOG2    = 11,
    parameter logic [ADDR_W-1:0]             RAM1_BASE    = 24'h00E000,
    parameter logic [ADDR_W-OFS_W-1:0]       WIN_BASE_RST = 8'h0F,
    parameter logic [ADDR_W-OFS_W-1:0]       WIN_MASK_RST = 8'hFF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic                    req_word,
    input  logic                    cfg_wr,
    input  logic                    cfg_sel,
    input  logic [DATA_W-1:0]       cfg_wdata,
    input  logic                    init_done,
    input  logic                    core_hold,
    input  logic                    xm_valid,
    input  logic [ADDR_W-1:0]       xm_addr,
    output logic                    sel_ram1,
    output logic                    sel_ram2,
    output logic                    sel_ext,
    output logic                    req_ready,
    output logic                    align_err,
    output logic [ADDR_W-OFS_W-1:0] seg_addr,
    output logic                    xm_sel_ram1
);

    localparam int PAGE_W  = ADDR_W - OFS_W;
    localparam int N_PROBE = 2;
    localparam int P_CORE  = 0;
    localparam int P_XM    = 1;

    logic              cfg_share;
    seg_mode_e         cfg_mode;
    logic              cfg_locked;
    logic [PAGE_W-1:0] win_base;
    logic [PAGE_W-1:0] win_mask;

    logic [ADDR_W-1:0]  probe [N_PROBE];
    logic [N_PROBE-1:0] fixed_hit;
    logic               win_hit;
    req_dec_t           dec;

    seg_cfg_regs #(
        .PAGE_W       (PAGE_W),
        .DATA_W       (DATA_W),
        .WIN_BASE_RST (WIN_BASE_RST),
        .WIN_MASK_RST (WIN_MASK_RST)
    ) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (cfg_wr),
        .wr_sel      (cfg_sel),
        .wr_data     (cfg_wdata),
        .init_strobe (init_done),
        .share       (cfg_share),
        .mode        (cfg_mode),
        .locked      (cfg_locked),
        .win_base    (win_base),
        .win_mask    (win_mask)
    );

    always_comb begin
        probe[P_CORE] = req_addr;
        probe[P_XM]   = xm_addr;
    end

    for (genvar p = 0; p < N_PROBE; p++) begin : g_probe
        seg_fixed_match #(
            .ADDR_W    (ADDR_W),
            .PAGE_LOG2 (RAM1_LOG2),
            .PAGE_BASE (RAM1_BASE)
        ) u_fix (
            .addr (probe[p]),
            .hit  (fixed_hit[p])
        );
    end

    seg_window_match #(
        .PAGE_W (PAGE_W)
    ) u_win (
        .page (req_addr[ADDR_W-1:OFS_W]),
        .base (win_base),
        .mask (win_mask),
        .hit  (win_hit)
    );

    always_comb begin
        logic live;
        dec.err   = req_valid & req_word & req_addr[0];
        live      = req_valid & ~dec.err;
        dec.ram1  = live & fixed_hit[P_CORE];
        dec.ram2  = live & ~fixed_hit[P_CORE] & win_hit;
        dec.ext   = live & ~fixed_hit[P_CORE] & ~win_hit;
        dec.ready = dec.ram1 | dec.ram2;
    end

    seg_addr_out #(
        .PAGE_W (PAGE_W)
    ) u_seg (
        .page (req_addr[ADDR_W-1:OFS_W]),
        .mode (cfg_mode),
        .en   (dec.ext),
        .seg  (seg_addr)
    );

    assign sel_ram1    = dec.ram1;
    assign sel_ram2    = dec.ram2;
    assign sel_ext     = dec.ext;
    assign req_ready   = dec.ready;
    assign align_err   = dec.err;
    assign xm_sel_ram1 = xm_valid & cfg_share & core_hold & fixed_hit[P_XM];

endmodule

// File: rtl/seg_region_decoder_chk.sv
module seg_region_decoder_chk
    import seg_dec_pkg::*;
#(
    parameter int                ADDR_W    = 24,
    parameter int                OFS_W     = 16,
    parameter int                RAM1_LOG2 = 11,
    parameter logic [ADDR_W-1:0] RAM1_BASE = 24'h00E000
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    req_valid,
    input logic [ADDR_W-1:0]       req_addr,
    input logic                    req_word,
    input logic                    sel_ram1,
    input logic                    sel_ram2,
    input logic                    sel_ext,
    input logic                    req_ready,
    input logic                    align_err,
    input logic [ADDR_W-OFS_W-1:0] seg_addr,
    input logic                    xm_sel_ram1,
    input logic                    xm_valid,
    input logic                    core_hold,
    input logic                    cfg_share,
    input seg_mode_e               cfg_mode,
    input logic                    cfg_locked
);

    localparam int PAGE_W = ADDR_W - OFS_W;

    logic unused_mid;
    assign unused_mid = ^req_addr[OFS_W-1:1];

    // R1
    ram1_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ram1 |-> (req_addr[ADDR_W-1:RAM1_LOG2] == RAM1_BASE[ADDR_W-1:RAM1_LOG2]));

    // R5
    one_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !align_err) |-> ($countones({sel_ram1, sel_ram2, sel_ext}) == 1));

    // R6
    misalign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |-> (!sel_ram1 && !sel_ram2 && !sel_ext && !req_ready && req_word && req_addr[0]));

    // R7
    ready_internal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> ((sel_ram1 || sel_ram2) && !sel_ext));

    // R8
    seg_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_ext |-> (seg_addr == '0));

    // R8
    seg_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == SEG_2BIT) |-> (seg_addr[PAGE_W-1:2] == '0));

    // R8
    seg_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == SEG_4BIT) |-> (seg_addr[PAGE_W-1:4] == '0));

    // R8
    seg_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_ext && cfg_mode == SEG_8BIT) |-> (seg_addr == req_addr[ADDR_W-1:OFS_W]));

    // R9
    xm_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xm_sel_ram1 |-> (xm_valid && core_hold && cfg_share));

    // R10
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_locked |=> (cfg_locked && $stable(cfg_share) && $stable(cfg_mode)));

endmodule

bind seg_region_decoder seg_region_decoder_chk #(
    .ADDR_W    (ADDR_W),
    .OFS_W     (OFS_W),
    .RAM1_LOG2 (RAM1_LOG2),
    .RAM1_BASE (RAM1_BASE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_word    (req_word),
    .sel_ram1    (sel_ram1),
    .sel_ram2    (sel_ram2),
    .sel_ext     (sel_ext),
    .req_ready   (req_ready),
    .align_err   (align_err),
    .seg_addr    (seg_addr),
    .xm_sel_ram1 (xm_sel_ram1),
    .xm_valid    (xm_valid),
    .core_hold   (core_hold),
    .cfg_share   (cfg_share),
    .cfg_mode    (cfg_mode),
    .cfg_locked  (cfg_locked)
);

// File: tb/seg_region_decoder_bench.sv
module seg_region_decoder_bench;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [23:0] req_addr = '0;
    logic        req_word = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        init_done = 1'b0;
    logic        core_hold = 1'b0;
    logic        xm_valid = 1'b0;
    logic [23:0] xm_addr = '0;
    logic        sel_ram1, sel_ram2, sel_ext, req_ready, align_err, xm_sel_ram1;
    logic [7:0]  seg_addr;

    int checks = 0;
    int failures = 0;

    logic       m_share;
    logic [1:0] m_mode;
    logic       m_locked;
    logic [7:0] m_base;
    logic [7:0] m_mask;

    always #(CLK_P / 2) clk = ~clk;

    seg_region_decoder u_seg_region_decoder (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .req_word    (req_word),
        .cfg_wr      (cfg_wr),
        .cfg_sel     (cfg_sel),
        .cfg_wdata   (cfg_wdata),
        .init_done   (init_done),
        .core_hold   (core_hold),
        .xm_valid    (xm_valid),
        .xm_addr     (xm_addr),
        .sel_ram1    (sel_ram1),
        .sel_ram2    (sel_ram2),
        .sel_ext     (sel_ext),
        .req_ready   (req_ready),
        .align_err   (align_err),
        .seg_addr    (seg_addr),
        .xm_sel_ram1 (xm_sel_ram1)
    );

    function automatic logic [7:0] mode_mask(logic [1:0] md);
        case (md)
            2'd0:    return 8'h00;
            2'd1:    return 8'h03;
            2'd2:    return 8'h0F;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [12:0] exp_vec(logic [23:0] a, logic w);
        logic r1, r2, ex, er;
        logic [7:0] sg;
        er = w && a[0];
        r1 = 1'b0; r2 = 1'b0; ex = 1'b0; sg = 8'h00;
        if (!er) begin
            if (a >= 24'h00E000 && a <= 24'h00E7FF) r1 = 1'b1;
            else if (((a[23:16] ^ m_base) & m_mask) == 8'h00) r2 = 1'b1;
            else begin
                ex = 1'b1;
                sg = a[23:16] & mode_mask(m_mode);
            end
        end
        return {r1, r2, ex, r1 | r2, er, sg};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_share = 1'b0; m_mode = 2'd0; m_locked = 1'b0;
        m_base = 8'h0F; m_mask = 8'hFF;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic write_sys(logic sh, logic [1:0] md, logic with_init);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = 1'b0;
        cfg_wdata = {13'd0, md, sh};
        init_done = with_init;
        @(negedge clk);
        cfg_wr = 1'b0; init_done = 1'b0;
        if (!m_locked && !with_init) begin
            m_share = sh; m_mode = md;
        end
        if (with_init) m_locked = 1'b1;
    endtask

    task automatic write_win(logic [7:0] base, logic [7:0] mask);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = 1'b1;
        cfg_wdata = {mask, base};
        @(negedge clk);
        cfg_wr = 1'b0;
        m_base = base; m_mask = mask;
    endtask

    task automatic check_access(logic [23:0] a, logic w, string tag);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_word = w;
        #1;
        check(tag, {19'd0, sel_ram1, sel_ram2, sel_ext, req_ready, align_err, seg_addr},
              {19'd0, exp_vec(a, w)});
    endtask

    task automatic check_xm(logic [23:0] a, logic hold, string tag);
        logic e;
        @(negedge clk);
        xm_valid = 1'b1; xm_addr = a; core_hold = hold;
        #1;
        e = m_share && hold && (a >= 24'h00E000) && (a <= 24'h00E7FF);
        check(tag, {31'd0, xm_sel_ram1}, {31'd0, e});
    endtask

    initial begin
        #(CLK_P * 150000);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        model_reset();
        apply_reset();

        // R11: idle outputs and reset configuration
        @(negedge clk);
        #1;
        check("R11 idle", {25'd0, sel_ram1, sel_ram2, sel_ext, req_ready, align_err, xm_sel_ram1, seg_addr != 0},
              32'd0);
        check_access(24'h123456, 1'b0, "R11 mode0 seg");
        check_xm(24'h00E100, 1'b1, "R11 share off");

        // R2: default window sweep, mode 0
        for (int pg = 0; pg < 256; pg++)
            check_access({8'(pg), 16'h3456}, 1'b0, "R2/R5/R7");

        // R8: every segmentation mode across all pages
        for (int md = 1; md < 4; md++) begin
            write_sys(1'b0, 2'(md), 1'b0);
            for (int pg = 0; pg < 256; pg++)
                check_access({8'(pg), 16'h9ABC}, 1'b0, "R8/R5");
        end

        // R1, R6: fixed page edges, byte and word
        for (int off = 0; off < 32; off++) begin
            check_access(24'h00DFF0 + 24'(off), 1'b0, "R1 low edge");
            check_access(24'h00DFF0 + 24'(off), 1'b1, "R1/R6 low edge");
            check_access(24'h00E7F0 + 24'(off), 1'b0, "R1 high edge");
            check_access(24'h00E7F0 + 24'(off), 1'b1, "R1/R6 high edge");
        end

        // R6: odd word on every page, even word nearby
        for (int pg = 0; pg < 256; pg++) begin
            check_access({8'(pg), 16'hE001}, 1'b1, "R6 odd word");
            check_access({8'(pg), 16'hE002}, 1'b1, "R6 even word");
        end

        // R3: reprogrammed window 0x20..0x2F
        write_win(8'h20, 8'hF0);
        for (int pg = 0; pg < 256; pg++)
            check_access({8'(pg), 16'h0100}, 1'b0, "R3 window");

        // R4: window over page 0, fixed page wins
        write_win(8'h00, 8'hFF);
        check_access(24'h00E000, 1'b0, "R4 overlap lo");
        check_access(24'h00E7FF, 1'b0, "R4 overlap hi");
        check_access(24'h00E800, 1'b0, "R4 past page");
        check_access(24'h001000, 1'b0, "R4 window only");
        check_access(24'h010000, 1'b0, "R4 next page");

        // R9: sharing and hold combinations
        for (int sh = 0; sh < 2; sh++) begin
            write_sys(1'(sh), 2'd3, 1'b0);
            for (int hd = 0; hd < 2; hd++) begin
                check_xm(24'h00DFFF, 1'(hd), "R9 below");
                check_xm(24'h00E000, 1'(hd), "R9 first");
                check_xm(24'h00E400, 1'(hd), "R9 mid");
                check_xm(24'h00E7FF, 1'(hd), "R9 last");
                check_xm(24'h00E800, 1'(hd), "R9 above");
                check_xm(24'h10E000, 1'(hd), "R9 alias");
            end
        end
        @(negedge clk);
        xm_valid = 1'b0;
        #1;
        check("R9 xm idle", {31'd0, xm_sel_ram1}, 32'd0);

        // R10: write in strobe cycle is dropped, later writes too
        write_sys(1'b0, 2'd1, 1'b1);
        write_sys(1'b0, 2'd0, 1'b0);
        check_access(24'h5A0000, 1'b0, "R10 mode kept");
        check_xm(24'h00E200, 1'b1, "R10 share kept");
        init_done = 1'b0;
        repeat (3) @(negedge clk);
        check_access(24'hC30000, 1'b0, "R10 still locked");

        // R3: window stays writable after lock
        write_win(8'h30, 8'hFF);
        check_access(24'h301234, 1'b0, "R3 after lock");
        check_access(24'h001234, 1'b0, "R3 old window gone");

        // R11: reset clears lock, mode and window
        apply_reset();
        check_access(24'h0F0010, 1'b0, "R11 window restored");
        check_access(24'h5A0000, 1'b0, "R11 mode cleared");
        write_sys(1'b1, 2'd2, 1'b0);
        check_access(24'h5A0000, 1'b0, "R11 unlocked write");
        check_xm(24'h00E010, 1'b1, "R11 share writable");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule